// File: doc/BRIEF.md
# Inbound Widget Device Access Filter

This block decides, for every operation an I/O widget sends toward the node, whether that operation may proceed. It keeps two pieces of state. One is a small set of per-widget inbound enables: one bit for widget 0 and one bit for each of widgets 8 to 15. The other is a 64-bit device-enable register that holds eight DMA-master enables for each high widget. A request is described by its widget number, a 3-bit device number and a reply flag. The block answers accept or reject in the same cycle, as pure logic over those fields and the stored enables.

Software loads the widget enables with a plain write. It sets device enables with a write-one-to-set write. Error-detection logic elsewhere in the node can switch off one misbehaving device. It does this by presenting that device's widget and device number on the error-clear input. Replies coming back from the widgets are never filtered.

Top module: `inbound_dev_filter`

## Requirements
- R1: After reset every enable is set, so every non-reply request from widget 0 or from widgets 8 to 15 is accepted.
- R2: A software write with `sw_sel`=0 loads the widget enables: widget 0 from `sw_wdata[0]` and widget 8+k from `sw_wdata[8+k]`. The new value governs decisions from the cycle after the write clock edge.
- R3: A software write with `sw_sel`=1 sets each device-enable bit whose data bit is 1 and leaves every bit whose data bit is 0 unchanged.
- R4: Device enable bit index (w-8)*8+d belongs to device d of widget w. Widget 8 uses bits 7:0 and widget 15 uses bits 63:56.
- R5: A non-reply request from widget 8 to 15 is accepted exactly when both that widget's enable and that device's enable are set.
- R6: An error clear naming widget 8 to 15 and device d clears only that one device-enable bit, from the next cycle on.
- R7: When an error clear and a software set hit the same device bit in the same cycle, the bit ends up cleared. A set of other bits in that cycle still takes effect.
- R8: A request with `req_is_reply`=1 is accepted whatever its widget, device or enable state.
- R9: Non-reply requests from widgets 1 to 7 are always rejected. Non-reply requests from widget 0 follow only the widget-0 enable, whatever the device number.
- R10: `req_accept` is combinational in the request fields and changes without a clock edge.
- R11: An error clear naming a widget below 8 has no effect on any enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, sets all enables |
| sw_wr_en | input | 1 | Software write strobe |
| sw_sel | input | 1 | 0 selects the widget enables, 1 selects the device enables |
| sw_wdata | input | 64 | Software write data |
| err_clr_valid | input | 1 | Hardware request to disable one device |
| err_widget | input | 4 | Widget of the device to disable |
| err_device | input | 3 | Device to disable |
| req_widget | input | 4 | Widget number of the inbound operation |
| req_device | input | 3 | Device number of the inbound operation |
| req_is_reply | input | 1 | Operation is a reply |
| req_accept | output | 1 | 1 = accept, 0 = reject |

## Verification
The decision takes zero cycles: the bench changes the request fields between edges, waits one time unit and samples `req_accept`. Writes and error clears take one cycle. The bench drives them on a falling edge, lets the next rising edge commit them, and then sweeps all 256 combinations of widget, device and reply flag only after the following falling edge. A bench model updated the same way predicts each result. That timing means a wrong register at the edge or a missing register update shows up as a mismatch in the sweep.

// File: rtl/inbound_dev_filter.sv
module inbound_dev_filter #(
  parameter int DEV_PER_W = 8,
  parameter int NUM_HI    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sw_wr_en,
  input  logic                       sw_sel,
  input  logic [NUM_HI*DEV_PER_W-1:0] sw_wdata,
  input  logic                       err_clr_valid,
  input  logic [3:0]                 err_widget,
  input  logic [2:0]                 err_device,
  input  logic [3:0]                 req_widget,
  input  logic [2:0]                 req_device,
  input  logic                       req_is_reply,
  output logic                       req_accept
);
  localparam int DEV_W = NUM_HI * DEV_PER_W;
  localparam int IW    = $clog2(DEV_W);

  logic              wid0_en;
  logic [NUM_HI-1:0] wid_hi_en;
  logic [DEV_W-1:0]  dev_en;

  logic [IW-1:0]    err_idx, req_idx;
  logic [DEV_W-1:0] set_mask, clr_mask;

  assign err_idx  = IW'({err_widget[2:0], err_device});
  assign req_idx  = IW'({req_widget[2:0], req_device});
  assign set_mask = (sw_wr_en && sw_sel) ? sw_wdata : '0;
  assign clr_mask = (err_clr_valid && err_widget[3]) ? (DEV_W'(1) << err_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wid0_en   <= 1'b1;
      wid_hi_en <= '1;
      dev_en    <= '1;
    end else begin
      if (sw_wr_en && !sw_sel) begin
        wid0_en   <= sw_wdata[0];
        wid_hi_en <= sw_wdata[8 +: NUM_HI];
      end
      dev_en <= (dev_en | set_mask) & ~clr_mask;
    end
  end

  always_comb begin
    if (req_is_reply)
      req_accept = 1'b1;
    else if (req_widget[3])
      req_accept = wid_hi_en[req_widget[2:0]] & dev_en[req_idx];
    else if (req_widget == 4'd0)
      req_accept = wid0_en;
    else
      req_accept = 1'b0;
  end
endmodule

// File: rtl/inbound_dev_filter_chk.sv
module inbound_dev_filter_chk #(
  parameter int DEV_PER_W = 8,
  parameter int NUM_HI    = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        sw_wr_en,
  input logic                        sw_sel,
  input logic [NUM_HI*DEV_PER_W-1:0] sw_wdata,
  input logic                        err_clr_valid,
  input logic [3:0]                  err_widget,
  input logic [2:0]                  err_device,
  input logic [3:0]                  req_widget,
  input logic [2:0]                  req_device,
  input logic                        req_is_reply,
  input logic                        req_accept,
  input logic                        wid0_en,
  input logic [NUM_HI-1:0]           wid_hi_en,
  input logic [NUM_HI*DEV_PER_W-1:0] dev_en
);
  localparam int DEV_W = NUM_HI * DEV_PER_W;
  localparam int IW    = $clog2(DEV_W);

  logic [IW-1:0] e_idx, r_idx;
  assign e_idx = IW'({err_widget[2:0], err_device});
  assign r_idx = IW'({req_widget[2:0], req_device});

  a_r8_reply_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    req_is_reply |-> req_accept);

  a_r9_low_widget_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_is_reply && !req_widget[3] && req_widget != 4'd0) |-> !req_accept);

  a_r5_both_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_is_reply && req_widget[3] && req_accept) |-> (wid_hi_en[req_widget[2:0]] && dev_en[r_idx]));

  a_r6_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr_valid && err_widget[3]) |=> !dev_en[$past(e_idx)]);

  a_r7_clear_beats_set: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr_valid && err_widget[3] && sw_wr_en && sw_sel && sw_wdata[e_idx]) |=> !dev_en[$past(e_idx)]);

  a_r3_no_fall_without_error: assert property (@(posedge clk) disable iff (!rst_n)
    !err_clr_valid |=> ((~dev_en & $past(dev_en)) == '0));

  a_r11_low_clear_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr_valid && !err_widget[3] && !(sw_wr_en && sw_sel)) |=> $stable(dev_en));

  a_r2_widget_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_wr_en && !sw_sel) |=> ($stable(wid_hi_en) && $stable(wid0_en)));
endmodule

bind inbound_dev_filter inbound_dev_filter_chk #(.DEV_PER_W(DEV_PER_W), .NUM_HI(NUM_HI)) u_chk (.*);

// File: tb/inbound_dev_filter_test.sv
`timescale 1ns/1ps
module inbound_dev_filter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sw_wr_en, sw_sel;
  logic [63:0] sw_wdata;
  logic        err_clr_valid;
  logic [3:0]  err_widget;
  logic [2:0]  err_device;
  logic [3:0]  req_widget;
  logic [2:0]  req_device;
  logic        req_is_reply;
  logic        req_accept;

  int errors = 0;
  int checks = 0;

  logic [15:0] m_wid;
  logic [63:0] m_dev;

  always #5 clk = ~clk;

  inbound_dev_filter uut (
    .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
    .err_clr_valid(err_clr_valid), .err_widget(err_widget), .err_device(err_device),
    .req_widget(req_widget), .req_device(req_device), .req_is_reply(req_is_reply),
    .req_accept(req_accept)
  );

  function automatic logic expect_acc(int w, int d, int rp);
    if (rp != 0) return 1'b1;
    if (w == 0) return m_wid[0];
    if (w < 8) return 1'b0;
    return m_wid[w] & m_dev[(w - 8) * 8 + d];
  endfunction

  task automatic sweep(string tag);
    for (int rp = 0; rp < 2; rp++)
      for (int w = 0; w < 16; w++)
        for (int d = 0; d < 8; d++) begin
          logic e;
          string kind;
          req_widget = 4'(w); req_device = 3'(d); req_is_reply = rp[0];
          #1;
          e = expect_acc(w, d, rp);
          checks++;
          if (rp != 0) kind = "R8";
          else if (w >= 1 && w <= 7) kind = "R9";
          else if (w == 0) kind = "R9";
          else kind = "R5/R10";
          if (req_accept !== e) begin
            errors++;
            $display("FAIL %s %s w=%0d d=%0d reply=%0d actual=%b expected=%b",
                     tag, kind, w, d, rp, req_accept, e);
          end
        end
  endtask

  task automatic cycle_idle();
    @(posedge clk);
    @(negedge clk);
    sw_wr_en = 0; sw_sel = 0; sw_wdata = '0; err_clr_valid = 0;
  endtask

  task automatic wr_widget(logic [15:0] v);
    sw_wr_en = 1; sw_sel = 0; sw_wdata = {48'd0, v};
    cycle_idle();
    m_wid = {v[15:8], 7'd0, v[0]};
  endtask

  task automatic wr_dev(logic [63:0] v);
    sw_wr_en = 1; sw_sel = 1; sw_wdata = v;
    cycle_idle();
    m_dev = m_dev | v;
  endtask

  task automatic hw_clear(int w, int d);
    err_clr_valid = 1; err_widget = 4'(w); err_device = 3'(d);
    cycle_idle();
    if (w >= 8) m_dev[(w - 8) * 8 + d] = 1'b0;
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; sw_wr_en = 0; sw_sel = 0; sw_wdata = '0;
    err_clr_valid = 0; err_widget = '0; err_device = '0;
    req_widget = '0; req_device = '0; req_is_reply = 0;
    m_wid = 16'hFF01; m_dev = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    sweep("R1");

    // R2: widget enable load
    wr_widget(16'h5A00);
    sweep("R2");
    wr_widget(16'hA5FF);
    sweep("R2");
    wr_widget(16'hFF01);

    // R6: single device disable; R4 mapping via which bit drops
    hw_clear(9, 3);
    sweep("R6/R4");
    hw_clear(15, 7);
    hw_clear(8, 0);
    sweep("R6/R4");

    // R11: low widget error clear ignored
    hw_clear(3, 5);
    hw_clear(0, 2);
    sweep("R11");

    // R3: written zeros leave bits alone, ones set
    wr_dev(64'd0);
    sweep("R3");
    wr_dev(64'h0000_0000_0000_0200);
    sweep("R3/R4");

    // Disable a whole byte of widget 12 then set a pattern back (R4)
    for (int d = 0; d < 8; d++) hw_clear(12, d);
    sweep("R4");
    wr_dev(64'h0000_0005_0000_0000);
    sweep("R4");

    // R7: clear and set on the same bit, plus a set elsewhere
    sw_wr_en = 1; sw_sel = 1; sw_wdata = 64'h0000_0002_0000_0000 | 64'h0000_0000_0000_0001;
    err_clr_valid = 1; err_widget = 4'd12; err_device = 3'd1;
    cycle_idle();
    m_dev = m_dev | 64'h0000_0002_0000_0001;
    m_dev[33] = 1'b0;
    sweep("R7");

    // R5 with widget disabled but devices enabled and vice versa
    wr_widget(16'h0F00);
    sweep("R5");
    wr_dev('1);
    wr_widget(16'hFF00);
    sweep("R5/R9");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule